// File: doc/BRIEF.md
# Cascadable Eight-Input Interrupt Controller

This block gathers up to eight interrupt requests and presents the most urgent one to a processor as a single interrupt line. When the processor acknowledges, the block returns an 8-bit vector. It is programmed over a small byte-wide register port with one address bit. A short series of setup words written after reset fixes the trigger style, the vector base, the cascade role and the end-of-interrupt style. Later writes adjust the mask, retire serviced interrupts and choose which status register an even-address read returns.

Two instances can be chained. A slave's interrupt output feeds one request input of a master. When the master acknowledges that input, it places the input number on a 3-bit cascade identifier bus. The slave whose programmed identity matches that number supplies the vector, and the master stays silent. All signals are synchronous to one clock. Request inputs are expected to be synchronous already. Bus strobes and the acknowledge are single-cycle pulses.

Top module: `intc8_cascade`

## Requirements
- R1: After reset the mask register reads 0xFF, the interrupt output is low and no vector is valid. Requests stay without effect until a setup sequence completes.
- R2: A write to address 0 with data bit 4 set starts setup. Bit 0 of that word asks for a fourth word. Bit 1 selects stand-alone use, with no cascade word. Bit 3 selects level triggering. The following odd-address writes are taken as setup words and never as the mask. Starting setup clears the mask and the in-service register and selects the request register for even reads.
- R3: The vector is the upper five bits of the second setup word joined with the 3-bit input number. It appears on `vec_o` with `vec_vld_o` high in the cycle after `inta_i`.
- R4: Once running, an odd-address write loads the mask, where bit n set blocks input n. An odd-address read returns the mask. A masked request is still latched but does not raise `int_o`.
- R5: Priority is fixed, with input 0 the most urgent. `int_o` rises only for an unmasked request that is more urgent than every in-service bit.
- R6: An acknowledge moves the winning request into the in-service register. In edge mode it also clears that request bit.
- R7: In edge mode a request bit is set by a rising input, and it stays set after the input falls. An input that is held high does not request again. In level mode the request bit follows the input.
- R8: Writing 0x20 to address 0 clears the lowest-numbered set in-service bit, and only that bit.
- R9: Writing 0x0A to address 0 selects the request register for even-address reads. Writing 0x0B selects the in-service register.
- R10: When bit 1 of the fourth setup word is set, an acknowledge leaves no in-service bit behind.
- R11: An acknowledge with no eligible request returns the base with input number 7 and changes no in-service bit.
- R12: A master is set by fourth-word bits 3:2 = 11, or by the strap pin when bits 3:2 are not 1x. On a master, the third word marks which inputs carry slaves. Acknowledging such an input drives its number on `cas_id_o` with `cas_vld_o` high during `inta_i`, and no vector is produced.
- R13: A slave is set by fourth-word bits 3:2 = 10. It uses the low three bits of its third word as its identity. It answers an acknowledge only when `cas_vld_i` is high and `cas_id_i` matches that identity. Otherwise its registers and vector output stay untouched.
- R14: With bit 4 of the fourth word set, a master raises `int_o` for a slave-carrying input even while that same input is in service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_i | input | 1 | Chip select for the register port |
| rd_i | input | 1 | Read strobe (one cycle) |
| wr_i | input | 1 | Write strobe (one cycle) |
| a0_i | input | 1 | Register address bit |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid the cycle after the read strobe |
| irq_i | input | 8 | Interrupt request inputs |
| ms_strap_i | input | 1 | Master role when not set by the fourth word |
| int_o | output | 1 | Interrupt to processor or master |
| inta_i | input | 1 | Acknowledge pulse |
| vec_o | output | 8 | Delivered vector |
| vec_vld_o | output | 1 | Vector valid |
| cas_id_i | input | 3 | Cascade identifier from master |
| cas_vld_i | input | 1 | Cascade identifier valid |
| cas_id_o | output | 3 | Cascade identifier to slaves |
| cas_vld_o | output | 1 | Cascade identifier valid |

## Verification
The bench sweeps every input and every pair of inputs in priority order. A reversed or off-by-one priority encoder would return the wrong vector, and a design that ignored the in-service level would raise the interrupt for a less urgent request. It holds inputs high across acknowledge and end-of-interrupt, so an edge detector that re-arms on level would show a second interrupt. It nests two in-service bits so that an end-of-interrupt clearing the wrong bit is exposed. It also re-runs setup over a live state to catch a mask or in-service register that survives setup. With a master and slave joined, it checks that a slave answers only its own identity and that the nested-slave exception appears only when enabled. A slave that answered every acknowledge would drive a second vector, and a master without the exception would stay silent.

// File: rtl/intc8_pkg.sv
package intc8_pkg;
  typedef enum logic [2:0] {
    CFG_IDLE,
    CFG_W2,
    CFG_W3,
    CFG_W4,
    CFG_RUN
  } cfg_state_e;

  typedef struct packed {
    logic level;
    logic single;
    logic aeoi;
    logic sfnm;
    logic buf_en;
    logic buf_master;
  } cfg_t;

  // bit positions the command decoder relies on
  localparam int B_INIT      = 4;
  localparam int B_NEED_W4   = 0;
  localparam int B_SINGLE    = 1;
  localparam int B_LEVEL     = 3;
  localparam int B_OCW3      = 3;
  localparam int B_RR        = 1;
  localparam int B_RIS       = 0;
  localparam int B_AEOI      = 1;
  localparam int B_BUF_MS    = 2;
  localparam int B_BUF_EN    = 3;
  localparam int B_SFNM      = 4;
  localparam logic [2:0] OP_NS_EOI = 3'b001;
endpackage

// File: rtl/intc8_cmd.sv
module intc8_cmd
  import intc8_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int NUM_IN = 8,
  localparam int ID_W  = $clog2(NUM_IN),
  localparam int BASE_W = DATA_W - ID_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_i,
  input  logic              wr_i,
  input  logic              a0_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              ms_strap_i,
  output cfg_t              cfg_o,
  output logic [BASE_W-1:0] base_o,
  output logic [NUM_IN-1:0] casc_mask_o,
  output logic [ID_W-1:0]   slave_id_o,
  output logic [NUM_IN-1:0] imr_o,
  output logic              rd_isr_o,
  output logic              running_o,
  output logic              is_master_o,
  output logic              init_o,
  output logic              eoi_o
);
  cfg_state_e st;
  logic       need_w4;
  logic       wr_even, wr_odd;

  assign wr_even   = cs_i & wr_i & ~a0_i;
  assign wr_odd    = cs_i & wr_i & a0_i;
  assign init_o    = wr_even & wdata_i[B_INIT];
  assign running_o = (st == CFG_RUN);
  assign eoi_o     = wr_even & running_o & ~wdata_i[B_INIT] & ~wdata_i[B_OCW3]
                     & (wdata_i[DATA_W-1:DATA_W-3] == OP_NS_EOI);
  assign is_master_o = cfg_o.buf_en ? cfg_o.buf_master : ms_strap_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= CFG_IDLE;
      need_w4     <= 1'b0;
      cfg_o       <= '0;
      base_o      <= '0;
      casc_mask_o <= '0;
      slave_id_o  <= '0;
      imr_o       <= '1;
      rd_isr_o    <= 1'b0;
    end else if (init_o) begin
      st           <= CFG_W2;
      need_w4      <= wdata_i[B_NEED_W4];
      cfg_o        <= '0;
      cfg_o.level  <= wdata_i[B_LEVEL];
      cfg_o.single <= wdata_i[B_SINGLE];
      imr_o        <= '0;
      rd_isr_o     <= 1'b0;
    end else if (wr_even && running_o && wdata_i[B_OCW3]) begin
      if (wdata_i[B_RR]) rd_isr_o <= wdata_i[B_RIS];
    end else if (wr_odd) begin
      case (st)
        CFG_W2: begin
          base_o <= wdata_i[DATA_W-1:ID_W];
          if (!cfg_o.single) st <= CFG_W3;
          else               st <= need_w4 ? CFG_W4 : CFG_RUN;
        end
        CFG_W3: begin
          casc_mask_o <= wdata_i[NUM_IN-1:0];
          slave_id_o  <= wdata_i[ID_W-1:0];
          st          <= need_w4 ? CFG_W4 : CFG_RUN;
        end
        CFG_W4: begin
          cfg_o.aeoi       <= wdata_i[B_AEOI];
          cfg_o.buf_en     <= wdata_i[B_BUF_EN];
          cfg_o.buf_master <= wdata_i[B_BUF_MS];
          cfg_o.sfnm       <= wdata_i[B_SFNM];
          st               <= CFG_RUN;
        end
        CFG_RUN: imr_o <= wdata_i[NUM_IN-1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/intc8_req.sv
module intc8_req #(
  parameter int NUM_IN = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_i,
  input  logic              level_i,
  input  logic [NUM_IN-1:0] irq_i,
  input  logic [NUM_IN-1:0] ack_clr_i,
  output logic [NUM_IN-1:0] irr_o
);
  for (genvar g = 0; g < NUM_IN; g++) begin : g_cell
    logic prev;
    always_ff @(posedge clk) begin
      if (rst) begin
        prev      <= 1'b0;
        irr_o[g]  <= 1'b0;
      end else begin
        prev <= irq_i[g];
        if (clr_i)        irr_o[g] <= 1'b0;
        else if (level_i) irr_o[g] <= irq_i[g];
        else if (ack_clr_i[g]) irr_o[g] <= 1'b0;
        else if (irq_i[g] && !prev) irr_o[g] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/intc8_prio.sv
module intc8_prio #(
  parameter int NUM_IN = 8,
  localparam int ID_W  = $clog2(NUM_IN)
) (
  input  logic [NUM_IN-1:0] irr_i,
  input  logic [NUM_IN-1:0] imr_i,
  input  logic [NUM_IN-1:0] isr_i,
  input  logic [NUM_IN-1:0] casc_mask_i,
  input  logic              nest_i,
  output logic              hit_o,
  output logic [ID_W-1:0]   win_o
);
  logic [NUM_IN-1:0] pend;
  logic              pv, sv;
  logic [ID_W-1:0]   pidx, sidx;

  always_comb begin
    pend = irr_i & ~imr_i;
    pv = 1'b0; pidx = '0;
    sv = 1'b0; sidx = '0;
    for (int i = NUM_IN - 1; i >= 0; i--) begin
      if (pend[i])  begin pv = 1'b1; pidx = ID_W'(i); end
      if (isr_i[i]) begin sv = 1'b1; sidx = ID_W'(i); end
    end
    hit_o = pv && (!sv || (pidx < sidx) ||
                   (nest_i && (pidx == sidx) && casc_mask_i[pidx]));
    win_o = pidx;
  end
endmodule

// File: rtl/intc8_cascade.sv
module intc8_cascade
  import intc8_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int NUM_IN = 8,
  localparam int ID_W  = $clog2(NUM_IN),
  localparam int BASE_W = DATA_W - ID_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic              a0_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [NUM_IN-1:0] irq_i,
  input  logic              ms_strap_i,
  output logic              int_o,
  input  logic              inta_i,
  output logic [DATA_W-1:0] vec_o,
  output logic              vec_vld_o,
  input  logic [ID_W-1:0]   cas_id_i,
  input  logic              cas_vld_i,
  output logic [ID_W-1:0]   cas_id_o,
  output logic              cas_vld_o
);
  cfg_t              cfg;
  logic [BASE_W-1:0] base;
  logic [NUM_IN-1:0] casc_mask, imr, irr, isr, ack_clr;
  logic [ID_W-1:0]   slave_id, win;
  logic              rd_isr, running, is_master, init_p, eoi_p, hit;
  logic              cascaded, ack_take, to_slave;

  intc8_cmd #(.DATA_W(DATA_W), .NUM_IN(NUM_IN)) cmd_i (
    .clk(clk), .rst(rst), .cs_i(cs_i), .wr_i(wr_i), .a0_i(a0_i),
    .wdata_i(wdata_i), .ms_strap_i(ms_strap_i), .cfg_o(cfg), .base_o(base),
    .casc_mask_o(casc_mask), .slave_id_o(slave_id), .imr_o(imr),
    .rd_isr_o(rd_isr), .running_o(running), .is_master_o(is_master),
    .init_o(init_p), .eoi_o(eoi_p)
  );

  intc8_req #(.NUM_IN(NUM_IN)) req_i (
    .clk(clk), .rst(rst), .clr_i(init_p), .level_i(cfg.level),
    .irq_i(irq_i), .ack_clr_i(ack_clr), .irr_o(irr)
  );

  intc8_prio #(.NUM_IN(NUM_IN)) prio_i (
    .irr_i(irr), .imr_i(imr), .isr_i(isr), .casc_mask_i(casc_mask),
    .nest_i(cfg.sfnm & is_master & ~cfg.single), .hit_o(hit), .win_o(win)
  );

  assign cascaded = running & ~cfg.single;
  assign ack_take = inta_i & running &
                    (~cascaded | is_master | (cas_vld_i & (cas_id_i == slave_id)));
  assign to_slave = cascaded & is_master & hit & casc_mask[win];
  assign cas_vld_o = inta_i & running & to_slave;
  assign cas_id_o  = cas_vld_o ? win : '0;

  always_comb begin
    ack_clr = '0;
    if (ack_take && hit && !cfg.level) ack_clr[win] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || init_p) begin
      isr <= '0;
    end else begin
      logic [NUM_IN-1:0] nxt;
      nxt = isr;
      if (eoi_p) nxt = nxt & ~(isr & (~isr + 1'b1));
      if (ack_take && hit && !cfg.aeoi) nxt[win] = 1'b1;
      isr <= nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      int_o     <= 1'b0;
      vec_o     <= '0;
      vec_vld_o <= 1'b0;
      rdata_o   <= '0;
    end else begin
      int_o     <= running & hit;
      vec_vld_o <= ack_take & ~to_slave;
      if (ack_take) vec_o <= {base, hit ? win : {ID_W{1'b1}}};
      if (cs_i && rd_i) rdata_o <= a0_i ? imr : (rd_isr ? isr : irr);
    end
  end
endmodule

// File: rtl/intc8_cascade_chk.sv
module intc8_cascade_chk #(
  parameter int DATA_W = 8,
  parameter int NUM_IN = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              running,
  input logic              int_o,
  input logic              inta_i,
  input logic              vec_vld_o,
  input logic              cas_vld_o,
  input logic              eoi_p,
  input logic [NUM_IN-1:0] isr,
  input logic [NUM_IN-1:0] imr,
  input logic              cs_i,
  input logic              rd_i,
  input logic              a0_i,
  input logic [DATA_W-1:0] rdata_o
);
  // R1
  idle_no_int_chk: assert property (@(posedge clk) disable iff (rst)
    !running |=> !int_o);
  // R3
  vec_follows_ack_chk: assert property (@(posedge clk) disable iff (rst)
    vec_vld_o |-> $past(inta_i));
  // R6
  one_new_service_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(isr & ~$past(isr)));
  // R8
  eoi_drops_one_chk: assert property (@(posedge clk) disable iff (rst)
    (eoi_p && isr != '0 && !inta_i) |=> $countones(isr) == $countones($past(isr)) - 1);
  // R4
  mask_readback_chk: assert property (@(posedge clk) disable iff (rst)
    (cs_i && rd_i && a0_i) |=> rdata_o == DATA_W'($past(imr)));
  // R12
  cascade_no_vector_chk: assert property (@(posedge clk) disable iff (rst)
    cas_vld_o |=> !vec_vld_o);
endmodule

bind intc8_cascade intc8_cascade_chk #(.DATA_W(DATA_W), .NUM_IN(NUM_IN)) chk_i (
  .clk(clk), .rst(rst), .running(running), .int_o(int_o), .inta_i(inta_i),
  .vec_vld_o(vec_vld_o), .cas_vld_o(cas_vld_o), .eoi_p(eoi_p), .isr(isr),
  .imr(imr), .cs_i(cs_i), .rd_i(rd_i), .a0_i(a0_i), .rdata_o(rdata_o)
);

// File: tb/intc8_cascade_tb.sv
`timescale 1ns/1ps
module intc8_cascade_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic       cs_m = 0, cs_s = 0, rd = 0, wr = 0, a0 = 0, inta = 0, use_casc = 0;
  logic [7:0] wd = 0, irq = 0, sirq = 0;
  logic [7:0] rd_m, rd_s, vec_m, vec_s, m_irq;
  logic       int_m, int_s, vv_m, vv_s, cv_m, cv_s;
  logic [2:0] cid_m, cid_s;
  int checks = 0, fails = 0;

  assign m_irq = use_casc ? {irq[7:3], int_s, irq[1:0]} : irq;

  intc8_cascade dut_i (
    .clk(clk), .rst(rst), .cs_i(cs_m), .rd_i(rd), .wr_i(wr), .a0_i(a0),
    .wdata_i(wd), .rdata_o(rd_m), .irq_i(m_irq), .ms_strap_i(1'b0),
    .int_o(int_m), .inta_i(inta), .vec_o(vec_m), .vec_vld_o(vv_m),
    .cas_id_i(3'd0), .cas_vld_i(1'b0), .cas_id_o(cid_m), .cas_vld_o(cv_m)
  );

  intc8_cascade slave_i (
    .clk(clk), .rst(rst), .cs_i(cs_s), .rd_i(rd), .wr_i(wr), .a0_i(a0),
    .wdata_i(wd), .rdata_o(rd_s), .irq_i(sirq), .ms_strap_i(1'b0),
    .int_o(int_s), .inta_i(inta), .vec_o(vec_s), .vec_vld_o(vv_s),
    .cas_id_i(cid_m), .cas_vld_i(cv_m), .cas_id_o(cid_s), .cas_vld_o(cv_s)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  task automatic wr_reg(input bit sl, input bit adr, input logic [7:0] d);
    @(negedge clk); cs_m = !sl; cs_s = sl; wr = 1; a0 = adr; wd = d;
    @(negedge clk); cs_m = 0; cs_s = 0; wr = 0;
  endtask

  task automatic rd_reg(input bit sl, input bit adr, output logic [7:0] d);
    @(negedge clk); cs_m = !sl; cs_s = sl; rd = 1; a0 = adr;
    @(negedge clk); cs_m = 0; cs_s = 0; rd = 0;
    d = sl ? rd_s : rd_m;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // acknowledge: captures cascade bus during the pulse and vectors after it
  logic [7:0] av_m, av_s; logic avv_m, avv_s, acv; logic [2:0] acid;
  task automatic ack();
    @(negedge clk); inta = 1; #1; acv = cv_m; acid = cid_m;
    @(negedge clk); inta = 0;
    av_m = vec_m; avv_m = vv_m; av_s = vec_s; avv_s = vv_s;
  endtask

  task automatic init_single(input logic [7:0] w1, input logic [7:0] base, input logic [7:0] w4);
    wr_reg(0, 0, w1); wr_reg(0, 1, base); wr_reg(0, 1, w4);
  endtask

  task automatic read_isr(input bit sl, output logic [7:0] d);
    wr_reg(sl, 0, 8'h0B); rd_reg(sl, 0, d); wr_reg(sl, 0, 8'h0A);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] d;
    idle(4); rst = 0; idle(1);
    // R1 reset state
    rd_reg(0, 1, d); chk("R1 mask after reset", d, 8'hFF);
    chk("R1 int after reset", int_m, 0);
    chk("R1 vec valid after reset", vv_m, 0);
    irq[0] = 1; idle(4); chk("R1 request before setup", int_m, 0); irq[0] = 0; idle(2);

    // stand-alone edge mode, base 0x40
    init_single(8'h13, 8'h40, 8'h01);
    rd_reg(0, 1, d); chk("R2 mask cleared by setup", d, 0);
    rd_reg(0, 0, d); chk("R2 even read is request reg", d, 0);

    for (int n = 0; n < 8; n++) begin
      irq[n] = 1; idle(3);
      chk("R5 single request raises int", int_m, 1);
      rd_reg(0, 0, d); chk("R7 edge latched", d, 1 << n);
      ack();
      chk("R3 vector", av_m, 8'h40 + n); chk("R3 vector valid", avv_m, 1);
      read_isr(0, d); chk("R6 in-service set", d, 1 << n);
      rd_reg(0, 0, d); chk("R6 request cleared by ack", d, 0);
      wr_reg(0, 0, 8'h20); read_isr(0, d); chk("R8 eoi clears", d, 0);
      idle(3); chk("R7 held input no retrigger", int_m, 0);
      irq[n] = 0; idle(2);
    end

    for (int i = 0; i < 8; i++) begin
      for (int j = i + 1; j < 8; j++) begin
        irq[i] = 1; irq[j] = 1; idle(3);
        ack(); chk("R5 higher input wins", av_m, 8'h40 + i);
        idle(3); chk("R5 lower blocked by service", int_m, 0);
        wr_reg(0, 0, 8'h20); idle(3); chk("R5 lower after eoi", int_m, 1);
        ack(); chk("R5 second vector", av_m, 8'h40 + j);
        wr_reg(0, 0, 8'h20); irq[i] = 0; irq[j] = 0; idle(2);
      end
    end

    // nested service, R8 clears most urgent only
    irq[5] = 1; idle(3); ack();
    irq[2] = 1; idle(3); chk("R5 urgent preempts", int_m, 1);
    ack(); chk("R5 nested vector", av_m, 8'h42);
    read_isr(0, d); chk("R6 two in service", d, 8'h24);
    wr_reg(0, 0, 8'h20); read_isr(0, d); chk("R8 clears lowest numbered", d, 8'h20);
    wr_reg(0, 0, 8'h20); read_isr(0, d); chk("R8 second eoi", d, 0);
    irq = 0; idle(2);

    for (int n = 0; n < 8; n++) begin
      wr_reg(0, 1, 8'(1 << n)); rd_reg(0, 1, d); chk("R4 mask readback", d, 1 << n);
      irq[n] = 1; idle(3); chk("R4 masked no int", int_m, 0);
      rd_reg(0, 0, d); chk("R4 masked still latched", d, 1 << n);
      wr_reg(0, 1, 8'h00); idle(3); chk("R4 unmask raises", int_m, 1);
      ack(); chk("R4 vector after unmask", av_m, 8'h40 + n);
      wr_reg(0, 0, 8'h20); irq[n] = 0; idle(2);
    end

    // R11 nothing pending
    ack(); chk("R11 empty ack vector", av_m, 8'h47); chk("R11 empty ack valid", avv_m, 1);
    read_isr(0, d); chk("R11 service unchanged", d, 0);

    // R2 setup over live state, R9 select
    wr_reg(0, 1, 8'h5A); wr_reg(0, 0, 8'h0B);
    irq[3] = 1; wr_reg(0, 1, 8'h00); idle(3); ack();
    rd_reg(0, 0, d); chk("R9 even read selects service", d, 8'h08);
    wr_reg(0, 0, 8'h13); rd_reg(0, 1, d); chk("R2 mask cleared at start", d, 0);
    wr_reg(0, 1, 8'h80); rd_reg(0, 1, d); chk("R2 second word not mask", d, 0);
    wr_reg(0, 1, 8'h01);
    irq[4] = 1; idle(3);
    rd_reg(0, 0, d); chk("R2 read select back to request", d, 8'h10);
    read_isr(0, d); chk("R2 service cleared", d, 0);
    ack(); chk("R3 new base", av_m, 8'h84);
    wr_reg(0, 0, 8'h20); irq = 0; idle(2);

    // R7 level mode
    init_single(8'h1B, 8'h60, 8'h01);
    irq[6] = 1; idle(3); rd_reg(0, 0, d); chk("R7 level follows high", d, 8'h40);
    irq[6] = 0; idle(3); rd_reg(0, 0, d); chk("R7 level follows low", d, 0);
    irq[6] = 1; idle(3); ack(); chk("R3 level vector", av_m, 8'h66);
    wr_reg(0, 0, 8'h20); idle(3); chk("R7 level re-asserts", int_m, 1);
    irq[6] = 0; idle(3); chk("R7 level drop", int_m, 0);

    // R10 automatic end of interrupt
    init_single(8'h13, 8'h40, 8'h03);
    irq[1] = 1; idle(3); ack(); chk("R10 vector", av_m, 8'h41);
    read_isr(0, d); chk("R10 no service left", d, 0);
    irq = 0; idle(2);

    // cascade: master base 0x20 slave on input 2, slave base 0x28
    use_casc = 1;
    wr_reg(0, 0, 8'h11); wr_reg(0, 1, 8'h20); wr_reg(0, 1, 8'h04); wr_reg(0, 1, 8'h0D);
    wr_reg(1, 0, 8'h11); wr_reg(1, 1, 8'h28); wr_reg(1, 1, 8'h02); wr_reg(1, 1, 8'h09);
    for (int n = 0; n < 8; n++) begin
      sirq[n] = 1; idle(6); chk("R12 master int from slave", int_m, 1);
      ack();
      chk("R12 cascade valid", acv, 1); chk("R12 cascade id", acid, 2);
      chk("R12 master silent", avv_m, 0);
      chk("R13 slave answers", avv_s, 1); chk("R13 slave vector", av_s, 8'h28 + n);
      wr_reg(1, 0, 8'h20); wr_reg(0, 0, 8'h20); sirq[n] = 0; idle(3);
    end
    sirq[6] = 1; irq[0] = 1; idle(6);
    ack();
    chk("R12 own input vector", av_m, 8'h20); chk("R12 no cascade for own input", acv, 0);
    chk("R13 slave ignores other id", avv_s, 0);
    read_isr(1, d); chk("R13 slave service untouched", d, 0);
    wr_reg(0, 0, 8'h20); idle(3); ack();
    chk("R13 slave after master", av_s, 8'h2E);
    wr_reg(1, 0, 8'h20); wr_reg(0, 0, 8'h20); sirq = 0; irq = 0; idle(3);

    // R14 nested slave requests
    sirq[4] = 1; idle(6); ack(); chk("R14 first slave vector", av_s, 8'h2C);
    sirq[1] = 1; idle(6); chk("R14 blocked without nesting", int_m, 0);
    wr_reg(1, 0, 8'h20); wr_reg(0, 0, 8'h20); idle(3);
    ack(); chk("R14 pending slave later", av_s, 8'h29);
    wr_reg(1, 0, 8'h20); wr_reg(0, 0, 8'h20); sirq = 0; idle(3);
    wr_reg(0, 0, 8'h11); wr_reg(0, 1, 8'h20); wr_reg(0, 1, 8'h04); wr_reg(0, 1, 8'h1D);
    sirq[4] = 1; idle(6); ack(); chk("R14 nest first vector", av_s, 8'h2C);
    sirq[1] = 1; idle(6); chk("R14 nested int raised", int_m, 1);
    ack(); chk("R14 nested slave vector", av_s, 8'h29);
    wr_reg(1, 0, 8'h20); wr_reg(1, 0, 8'h20); wr_reg(0, 0, 8'h20); sirq = 0; idle(3);

    summary();
    $finish;
  end
endmodule